// File: doc/BRIEF.md
# Machine System Timer with Aligned Time Export

This block keeps a free-running 64-bit time count for a processor and raises a level interrupt when the count reaches a programmable 64-bit threshold. Software reaches the count and the threshold through four 32-bit words on a simple register bus. Each request is a single `busSel` cycle, and every request is answered by a one-cycle acknowledge in the next cycle.

The count is split into two 32-bit words so that no single 64-bit adder sits in one clock period. The low word advances on every clock. Its carry is kept in a flip-flop and added to the high word one clock later.

Other on-chip logic receives the time on a 64-bit port. On that port the low word is delayed by one register stage so that it matches the high word, which lags by one clock. The exported value therefore never shows a torn wrap. The same exported value also feeds a registered comparator, which drives the interrupt pin.

Top module: `sys_timer`

## Requirements
- R1: While reset is asserted, `timeOut` is zero, `irqOut` is low and `busAck` is low, and both the time and the threshold are cleared to zero.
- R2: Address bits [3:2] select the word: 0x00 is time low, 0x04 is time high, 0x08 is threshold low and 0x0C is threshold high. Address bits [1:0] are ignored. An address with any bit at or above bit 4 set is unmapped: it reads as zero, and a write to it changes nothing.
- R3: The live time increments by one on every clock. A carry out of the low word is added to the high word on the following clock.
- R4: `timeOut` equals the live time delayed by one clock. With no time write, it grows by exactly one per clock, including across a low-word wrap from 0xFFFFFFFF.
- R5: A write to a time word replaces that word in that cycle instead of the increment. After a low-word write followed by a high-word write in the next cycle, `timeOut` shows {written high, written low} one clock after the high write.
- R6: A write to a threshold word changes only the addressed half.
- R7: `irqOut` is the registered result of (`timeOut` >= threshold), compared as unsigned 64-bit values. It changes one clock after that condition changes, and it stays high as long as the condition holds.
- R8: `irqOut` falls when the time or the threshold is rewritten so that the time is below the threshold.
- R9: A read is acknowledged one clock after its request, and `busRdata` is valid while `busAck` is high. A time read returns the live time, which equals `timeOut` + 1 taken in the request cycle, so the high word includes any pending carry. A threshold read returns the stored word.
- R10: A write is acknowledged one clock after its request with `busRdata` zero. No acknowledge appears without a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Request strobe, one cycle per access |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address of the word |
| busWdata | input | WORD_W | Write data |
| busRdata | output | WORD_W | Read data, valid with `busAck` |
| busAck | output | 1 | Acknowledge, one cycle after the request |
| timeOut | output | 2*WORD_W | Aligned time for other logic |
| irqOut | output | 1 | Level interrupt, active high |

## Verification
The assertions check four things on every cycle: that the exported time steps by one whenever no time word was written in the two preceding cycles, that the interrupt follows the previous comparison, that the threshold holds still without a write, and that acknowledges and unmapped reads behave correctly. Only the bench scenarios can show the cases that need a particular setup. These are the exported value passing cleanly across a low-word wrap, a read of the high word while the carry is still pending, the value that appears right after a split 64-bit write, and the interrupt rising at the exact cycle the threshold is crossed and falling after each kind of rewrite.

// File: rtl/sys_timer_pkg.sv
package sys_timer_pkg;

  // Word selected by address bits [3:2]; the order is the register layout.
  typedef enum logic [1:0] {
    WORD_TLO = 2'd0,
    WORD_THI = 2'd1,
    WORD_CLO = 2'd2,
    WORD_CHI = 2'd3
  } tmr_word_e;

  // Strobes from control to datapath. Index 0 = low half, 1 = high half.
  typedef struct packed {
    logic [1:0] wrTime;
    logic [1:0] wrCmp;
    logic       rdEn;
    tmr_word_e  rdWord;
  } tmr_stb_t;

endpackage

// File: rtl/sys_timer_ctrl.sv
module sys_timer_ctrl
  import sys_timer_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output tmr_stb_t          stb,
  output logic              busAck
);

  localparam int SEL_LSB = 2;

  logic      mapped;
  logic      wrHit;
  logic      rdHit;
  tmr_word_e word;
  logic      unusedAddrLsb;

  assign unusedAddrLsb = ^busAddr[SEL_LSB-1:0];

  generate
    if (ADDR_W > SEL_LSB + 2) begin : g_decodeHigh
      assign mapped = ~|busAddr[ADDR_W-1:SEL_LSB+2];
    end else begin : g_allMapped
      assign mapped = 1'b1;
    end
  endgenerate

  assign word  = tmr_word_e'(busAddr[SEL_LSB+1:SEL_LSB]);
  assign wrHit = busSel & busWe & mapped;
  assign rdHit = busSel & ~busWe & mapped;

  always_comb begin
    stb        = '0;
    stb.rdEn   = rdHit;
    stb.rdWord = word;
    if (wrHit) begin
      case (word)
        WORD_TLO: stb.wrTime[0] = 1'b1;
        WORD_THI: stb.wrTime[1] = 1'b1;
        WORD_CLO: stb.wrCmp[0]  = 1'b1;
        default:  stb.wrCmp[1]  = 1'b1;
      endcase
    end
  end

  // R9, R10: every request is acknowledged one clock later
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busAck <= 1'b0;
    else       busAck <= busSel;
  end

endmodule

// File: rtl/sys_timer_dp.sv
module sys_timer_dp
  import sys_timer_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  tmr_stb_t            stb,
  input  logic [WORD_W-1:0]   wrData,
  output logic [2*WORD_W-1:0] timeOut,
  output logic [2*WORD_W-1:0] cmpVal,
  output logic [WORD_W-1:0]   rdData
);

  localparam int HALVES = 2;

  logic [WORD_W-1:0] loQ;
  logic [WORD_W-1:0] hiQ;
  logic              carryQ;
  logic [WORD_W-1:0] loAlignQ;
  logic [WORD_W:0]   loSum;
  logic [WORD_W-1:0] hiLive;
  logic [WORD_W-1:0] rdMux;

  // R3: 33-bit add exposes the carry out of the low word
  assign loSum  = {1'b0, loQ} + {{WORD_W{1'b0}}, 1'b1};
  assign hiLive = hiQ + {{(WORD_W-1){1'b0}}, carryQ};

  // R3, R5: low word and registered carry; a write replaces the increment
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loQ    <= '0;
      carryQ <= 1'b0;
    end else if (stb.wrTime[0]) begin
      loQ    <= wrData;
      carryQ <= 1'b0;
    end else begin
      {carryQ, loQ} <= loSum;
    end
  end

  // R3, R5: high word takes the carry one clock late unless written
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              hiQ <= '0;
    else if (stb.wrTime[1]) hiQ <= wrData;
    else                    hiQ <= hiLive;
  end

  // R4: low word re-timed to line up with the lagging high word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) loAlignQ <= '0;
    else       loAlignQ <= loQ;
  end

  assign timeOut = {hiQ, loAlignQ};

  // R6: each threshold half has its own write strobe
  generate
    for (genvar h = 0; h < HALVES; h++) begin : g_cmpHalf
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           cmpVal[h*WORD_W +: WORD_W] <= '0;
        else if (stb.wrCmp[h]) cmpVal[h*WORD_W +: WORD_W] <= wrData;
      end
    end
  endgenerate

  // R9: live time and stored threshold readback
  always_comb begin
    case (stb.rdWord)
      WORD_TLO: rdMux = loQ;
      WORD_THI: rdMux = hiLive;
      WORD_CLO: rdMux = cmpVal[WORD_W-1:0];
      default:  rdMux = cmpVal[2*WORD_W-1:WORD_W];
    endcase
  end

  // R2, R10: zero for writes and unmapped reads
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rdData <= '0;
    else if (stb.rdEn) rdData <= rdMux;
    else               rdData <= '0;
  end

endmodule

// File: rtl/sys_timer_cmp.sv
module sys_timer_cmp #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] timeVal,
  input  logic [TIME_W-1:0] cmpVal,
  output logic              irqOut
);

  logic reached;

  assign reached = (timeVal >= cmpVal);

  // R7: registered level, one clock behind the condition
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= reached;
  end

endmodule

// File: rtl/sys_timer.sv
module sys_timer
  import sys_timer_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWe,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [WORD_W-1:0]   busWdata,
  output logic [WORD_W-1:0]   busRdata,
  output logic                busAck,
  output logic [2*WORD_W-1:0] timeOut,
  output logic                irqOut
);

  localparam int TIME_W = 2 * WORD_W;

  tmr_stb_t          stb;
  logic [TIME_W-1:0] cmpVal;

  sys_timer_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWe   (busWe),
    .busAddr (busAddr),
    .stb     (stb),
    .busAck  (busAck)
  );

  sys_timer_dp #(.WORD_W(WORD_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (busWdata),
    .timeOut (timeOut),
    .cmpVal  (cmpVal),
    .rdData  (busRdata)
  );

  sys_timer_cmp #(.TIME_W(TIME_W)) u_cmp (
    .clk     (clk),
    .rstN    (rstN),
    .timeVal (timeOut),
    .cmpVal  (cmpVal),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/sys_timer_chk.sv
module sys_timer_chk #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic                busSel,
  input logic                busWe,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [WORD_W-1:0]   busRdata,
  input logic                busAck,
  input logic [2*WORD_W-1:0] timeOut,
  input logic [2*WORD_W-1:0] cmpVal,
  input logic                irqOut
);

  logic [1:0] cyc;
  logic       mapped;
  logic       timeWr;
  logic       cmpWr;
  logic       unmappedRd;

  assign mapped     = (busAddr >> 4) == '0;
  assign timeWr     = busSel & busWe & mapped & ~busAddr[3];
  assign cmpWr      = busSel & busWe & mapped & busAddr[3];
  assign unmappedRd = busSel & ~busWe & ~mapped;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  // R4
  time_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cyc == 2'd3 && !$past(timeWr) && !$past(timeWr, 2))
      |-> timeOut == $past(timeOut) + 1'b1);

  // R7
  irq_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 2'd2) |-> irqOut == $past(timeOut >= cmpVal));

  // R6
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 2'd1 && !$past(cmpWr)) |-> $stable(cmpVal));

  // R10
  ack_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 2'd1) |-> busAck == $past(busSel));

  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 2'd1 && $past(unmappedRd)) |-> busRdata == '0);

endmodule

bind sys_timer sys_timer_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWe    (busWe),
  .busAddr  (busAddr),
  .busRdata (busRdata),
  .busAck   (busAck),
  .timeOut  (timeOut),
  .cmpVal   (cmpVal),
  .irqOut   (irqOut)
);

// File: tb/sys_timer_tb.sv
`timescale 1ns/1ps
module sys_timer_tb;

  localparam int WORD_W = 32;
  localparam int ADDR_W = 5;
  localparam int WATCHDOG = 20000;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                busSel = 1'b0;
  logic                busWe = 1'b0;
  logic [ADDR_W-1:0]   busAddr = '0;
  logic [WORD_W-1:0]   busWdata = '0;
  logic [WORD_W-1:0]   busRdata;
  logic                busAck;
  logic [2*WORD_W-1:0] timeOut;
  logic                irqOut;

  int checks = 0;
  int errors = 0;
  bit doneFlag = 1'b0;

  logic [32:0] expQ[$];   // bit 32: read, [31:0]: expected data
  string       tagQ[$];

  always #4 clk = ~clk;   // 125 MHz

  sys_timer #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busAck(busAck), .timeOut(timeOut), .irqOut(irqOut)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver: called at a falling edge, one request cycle
  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    expQ.push_back({1'b0, 32'h0});
    tagQ.push_back("R10 write ack");
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    expQ.push_back({1'b1, e});
    tagQ.push_back(tag);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  // Monitor: pops one expected item per acknowledge
  always @(negedge clk) begin
    if (rstN && busAck) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R10 spurious ack", 64'(busAck), 64'h0);
      end else begin
        logic [32:0] it;
        string t;
        it = expQ.pop_front();
        t  = tagQ.pop_front();
        chk(busRdata == it[31:0], t, 64'(busRdata), 64'(it[31:0]));
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!doneFlag) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] prev;
    logic [63:0] lv;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(timeOut == 64'h0, "R1 time in reset", timeOut, 64'h0);
    chk(irqOut == 1'b0, "R1 irq in reset", 64'(irqOut), 64'h0);
    chk(busAck == 1'b0, "R1 ack in reset", 64'(busAck), 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(timeOut == 64'h0, "R4 first export", timeOut, 64'h0);
    chk(irqOut == 1'b1, "R7 zero reaches zero", 64'(irqOut), 64'h1);
    @(negedge clk);
    chk(timeOut == 64'h1, "R3 count", timeOut, 64'h1);

    // R5 split write, then R4 step across a low-word wrap
    busWrite(5'h00, 32'hFFFF_FFF0);
    busWrite(5'h04, 32'h0000_0005);
    chk(timeOut == 64'h5_FFFF_FFF0, "R5 written time", timeOut, 64'h5_FFFF_FFF0);
    prev = timeOut;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(timeOut == prev + 64'd1, "R4 step", timeOut, prev + 64'd1);
      prev = timeOut;
    end
    chk(timeOut == 64'h6_0000_0018, "R4 after wrap", timeOut, 64'h6_0000_0018);

    // R9 reads with the carry pending (R3)
    busWrite(5'h00, 32'hFFFF_FFFE);
    busWrite(5'h04, 32'h0000_0007);
    @(negedge clk);
    chk(timeOut == 64'h7_FFFF_FFFF, "R4 before carry", timeOut, 64'h7_FFFF_FFFF);
    lv = timeOut + 64'd1;
    busRead(5'h04, lv[63:32], "R9 high with pending carry");
    lv = timeOut + 64'd1;
    busRead(5'h00, lv[31:0], "R9 live low");

    // R6 threshold halves, R8 drop by threshold rewrite
    busWrite(5'h08, 32'h0000_1234);
    busWrite(5'h0C, 32'h0000_ABCD);
    busWrite(5'h08, 32'h0000_5555);
    busRead(5'h0C, 32'h0000_ABCD, "R6 high half kept");
    busRead(5'h08, 32'h0000_5555, "R6 low half");
    chk(irqOut == 1'b0, "R8 drop by threshold", 64'(irqOut), 64'h0);

    // R7 crossing at an exact cycle
    busWrite(5'h08, 32'h0000_0020);
    busWrite(5'h0C, 32'h0000_0009);
    busWrite(5'h00, 32'h0000_0010);
    busWrite(5'h04, 32'h0000_0009);
    chk(timeOut == 64'h9_0000_0010, "R5 written time", timeOut, 64'h9_0000_0010);
    repeat (16) @(negedge clk);
    chk(timeOut == 64'h9_0000_0020, "R4 at threshold", timeOut, 64'h9_0000_0020);
    chk(irqOut == 1'b0, "R7 latency", 64'(irqOut), 64'h0);
    @(negedge clk);
    chk(irqOut == 1'b1, "R7 rise", 64'(irqOut), 64'h1);
    repeat (5) @(negedge clk);
    chk(irqOut == 1'b1, "R7 level held", 64'(irqOut), 64'h1);

    // R8 drop by time rewrite
    busWrite(5'h04, 32'h0);
    chk(irqOut == 1'b1, "R7 latency on drop", 64'(irqOut), 64'h1);
    @(negedge clk);
    chk(irqOut == 1'b0, "R8 drop by time", 64'(irqOut), 64'h0);

    // R2 unmapped offsets and ignored low address bits
    busWrite(5'h18, 32'hFFFF_FFFF);
    busRead(5'h18, 32'h0, "R2 unmapped reads zero");
    busRead(5'h08, 32'h0000_0020, "R2 threshold low untouched");
    busRead(5'h0E, 32'h0000_0009, "R2 low address bits ignored");
    prev = timeOut;
    @(negedge clk);
    chk(timeOut == prev + 64'd1, "R2 time untouched", timeOut, prev + 64'd1);

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R10 all requests acknowledged", 64'(expQ.size()), 64'h0);

    doneFlag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule